// File: doc/BRIEF.md
# Cascaded Watchdog Timer with Stop Lock

This block is a watchdog made of two 8-bit down-counters and a divide-by-16 prescaler. It sits behind one 8-bit control register. After reset the watchdog does nothing until software first writes the control register. From then on, every write loads both counters with 0xFF again. If software stops writing, the high counter underflows and the block raises a one-cycle internal reset pulse.

Bit 7 of the register picks what drives the high counter. It can be the underflow of the low counter, which gives a long cascaded timeout. It can also be the prescaler tick itself, which gives a short direct timeout. Bit 6 is a lock: once set, a stop-instruction strobe from the CPU raises the reset pulse. Software cannot clear this bit. Only the reset pulse or the hardware reset clears it.

A read returns the two control bits and, below them, the top six bits of the high counter. Software can use this to see how far the countdown has gone. The block runs on a single clock. The prescaler produces a one-cycle enable, and no derived clock is used.

Top module: `wdog_cascade`

## Requirements
- R1: After hardware reset the watchdog is idle. `wdt_rst_pulse` stays 0 and `bus_rdata` reads 0x3F for as long as no write occurs.
- R2: A write to the control register (`bus_wr`=1 at a clock edge) starts counting. It also loads the low and high counters with 0xFF and restarts the prescaler.
- R3: The prescaler gives one tick every 16 clocks. The first tick after a write decrements the counters on the 16th clock edge after the write edge.
- R4: With bit 7 = 0 (cascaded), the high counter decrements once per low-counter underflow, which is once every 4096 clocks.
- R5: When the high counter underflows, `wdt_rst_pulse` is 1 for exactly one cycle. In direct mode this happens on the 4096th clock edge after the write edge.
- R6: Bit 7 selects the high counter's count source (1 = prescaler tick, 0 = low-counter underflow). It reads back as written and clears to 0 on reset.
- R7: Bit 6 is a lock. Writing 1 sets it. A later write of 0 leaves it at 1, and it reads back in bit 6.
- R8: While the lock is 1, a `stop_exec` strobe produces the reset pulse on the next clock edge. While the lock is 0, the strobe has no effect.
- R9: The reset pulse returns the block to the idle state: counters at 0xFF, both control bits 0, no counting, and `bus_rdata` reads 0x3F.
- R10: If a write falls in the same cycle as a high-counter underflow, the write wins. The counters reload and no reset pulse is produced.
- R11: The read layout of `bus_rdata` is {bit 7 source select, bit 6 lock, bits 5..0 = high counter bits 7..2}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the watchdog input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe for the control register |
| bus_wdata | input | 8 | Write data; bit 7 = source select, bit 6 = lock |
| bus_rdata | output | 8 | Read view of the control register and the high counter |
| stop_exec | input | 1 | Strobe: the CPU executed a stop instruction |
| wdt_rst_pulse | output | 1 | One-cycle registered internal reset request |

## Verification
A wrong prescaler phase or count source shows up in the high-counter bits of `bus_rdata`. In direct mode the error appears within one 64-clock step. In cascaded mode it appears at the 16384-clock boundary, where bits 5..0 drop from 0x3F to 0x3E. A wrong underflow or priority shows up on `wdt_rst_pulse`. The pulse may come one edge early or late in the 4096-clock window, or appear when a write lands on the underflow edge. A lock that can be cleared, or a pulse that does not return the block to idle, shows up on the next read as a bit 6/bit 7 value or a counter field other than 0x3F.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned SHOW_W  = 6;
  localparam int unsigned SEL_BIT = 7;
  localparam int unsigned LCK_BIT = 6;

  typedef struct packed {
    logic src_sel;
    logic lock;
    logic running;
  } wdog_ctrl_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic enable,
  output logic tick
);
  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clear)       pre_d = '0;
    else if (enable) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = enable && !clear && (pre_q == {PRE_W{1'b1}});

  // R3: a tick cannot come twice in a row with a divider wider than 1 bit
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (PRE_W > 1 && tick) |=> !tick);
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         uflow
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = {W{1'b1}};
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= {W{1'b1}};
    else        cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign uflow = dec && !load && (cnt_q == '0);

  // R2: a load always leaves the counter at all ones
  assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == {W{1'b1}}));
  // R3: without load the counter moves by at most one step
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             soft_clr,
  output wdog_ctrl_t       ctrl
);
  wdog_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (soft_clr) begin
      ctrl_d = '0;
    end else if (wr) begin
      ctrl_d.running = 1'b1;
      ctrl_d.src_sel = wdata[SEL_BIT];
      ctrl_d.lock    = ctrl_q.lock | wdata[LCK_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R7: lock only falls through the internal reset pulse
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.lock && !soft_clr) |=> ctrl.lock);
  // R2: a write (without clear) starts the watchdog
  assert_write_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !soft_clr) |=> ctrl.running);
endmodule

// File: rtl/wdog_cascade.sv
module wdog_cascade
  import wdog_pkg::*;
#(
  parameter int unsigned PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             stop_exec,
  output logic             wdt_rst_pulse
);
  localparam int unsigned SHOW_LSB = CNT_W - SHOW_W;

  wdog_ctrl_t       ctrl;
  logic             pulse_q, pulse_d;
  logic             reload, tick;
  logic [CNT_W-1:0] lo_cnt, hi_cnt;
  logic             lo_uf, hi_uf, hi_dec;

  assign reload = bus_wr || pulse_q;

  wdog_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_wr),
    .wdata    (bus_wdata),
    .soft_clr (pulse_q),
    .ctrl     (ctrl)
  );

  wdog_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (reload),
    .enable (ctrl.running),
    .tick   (tick)
  );

  wdog_downcnt #(.W(CNT_W)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (reload),
    .dec   (tick),
    .cnt   (lo_cnt),
    .uflow (lo_uf)
  );

  assign hi_dec = ctrl.src_sel ? tick : lo_uf;

  wdog_downcnt #(.W(CNT_W)) u_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (reload),
    .dec   (hi_dec),
    .cnt   (hi_cnt),
    .uflow (hi_uf)
  );

  always_comb begin
    pulse_d = 1'b0;
    if (!pulse_q) begin
      if (hi_uf && !bus_wr)           pulse_d = 1'b1;
      else if (stop_exec && ctrl.lock) pulse_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign wdt_rst_pulse = pulse_q;
  assign bus_rdata     = {ctrl.src_sel, ctrl.lock, hi_cnt[CNT_W-1:SHOW_LSB]};

  // R5: the reset request is a single-cycle pulse
  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_pulse |=> !wdt_rst_pulse);
  // R9: the pulse returns the block to idle with a full high counter
  assert_pulse_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_pulse |=> (!ctrl.running && hi_cnt == {CNT_W{1'b1}} && bus_rdata[7:6] == 2'b00));
  // R10: a write with no locked stop request never leads to a pulse
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !(stop_exec && ctrl.lock)) |=> !wdt_rst_pulse);
  // R1: while idle and unwritten, the high counter holds
  assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.running && !bus_wr) |=> $stable(hi_cnt));
  // R8: an unlocked stop strobe outside a timeout raises nothing
  assert_stop_unlocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_exec && !ctrl.lock && !hi_uf) |=> !wdt_rst_pulse);
endmodule

// File: tb/tb_wdog_cascade.sv
module tb_wdog_cascade;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       stop_exec;
  logic       wdt_rst_pulse;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic lock_m;

  always #2 clk = ~clk;

  wdog_cascade dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .stop_exec     (stop_exec),
    .wdt_rst_pulse (wdt_rst_pulse)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung (act %0d cycles, exp fewer)", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // expected high counter after k edges past the write edge
  function automatic logic [7:0] hi_exp(input logic sel, input int k);
    int ticks = k / 16;
    if (sel) return 8'(255 - ticks);
    return 8'(255 - ticks / 256);
  endfunction

  function automatic logic [7:0] rd_exp(input logic sel, input logic lk, input int k);
    logic [7:0] h = hi_exp(sel, k);
    return {sel, lk, h[7:2]};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: act 0x%02h exp 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] v);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_wdata = v;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic watch_no_pulse(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wdt_rst_pulse) seen = 1'b1;
    end
    check(req, {7'd0, seen}, 8'h00);
  endtask

  initial begin
    logic [7:0] v;
    int k;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00; stop_exec = 1'b0;
    lock_m = 1'b0;
    wait_edges(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R6 / R11: reset state and idle hold
    check("R1 reset read", bus_rdata, 8'h3F);
    check("R6 sel cleared at reset", {7'd0, bus_rdata[7]}, 8'h00);
    watch_no_pulse("R1 idle no pulse", 5000);
    check("R1 idle read after 5000", bus_rdata, 8'h3F);

    // R8: unlocked stop strobe ignored
    @(negedge clk); stop_exec = 1'b1;
    @(negedge clk); stop_exec = 1'b0;
    check("R8 unlocked stop no pulse", {7'd0, wdt_rst_pulse}, 8'h00);
    check("R8 unlocked stop state", bus_rdata, 8'h3F);

    // R3 / R5: direct mode phase and timeout edge
    do_write(8'h80);
    check("R2 write reload read", bus_rdata, 8'hBF);
    wait_edges(63);
    check("R3 direct before 64", bus_rdata, rd_exp(1'b1, 1'b0, 63));
    wait_edges(1);
    check("R3 direct at 64", bus_rdata, rd_exp(1'b1, 1'b0, 64));
    wait_edges(4095 - 64);
    check("R5 no pulse at 4095", {7'd0, wdt_rst_pulse}, 8'h00);
    wait_edges(1);
    check("R5 pulse at 4096", {7'd0, wdt_rst_pulse}, 8'h01);
    wait_edges(1);
    check("R5 pulse one cycle", {7'd0, wdt_rst_pulse}, 8'h00);
    check("R9 idle read after pulse", bus_rdata, 8'h3F);
    watch_no_pulse("R9 stays stopped", 5000);

    // R10: write on the underflow edge wins
    do_write(8'h80);
    wait_edges(4095);
    bus_wr = 1'b1; bus_wdata = 8'h80;
    @(negedge clk);
    bus_wr = 1'b0;
    check("R10 no pulse on write-underflow", {7'd0, wdt_rst_pulse}, 8'h00);
    check("R10 reloaded", bus_rdata, 8'hBF);
    wait_edges(64);
    check("R10 restarted count", bus_rdata, rd_exp(1'b1, 1'b0, 64));

    // R4: cascaded mode boundary
    do_write(8'h00);
    wait_edges(16383);
    check("R4 cascade at 16383", bus_rdata, rd_exp(1'b0, 1'b0, 16383));
    wait_edges(1);
    check("R4 cascade at 16384", bus_rdata, 8'h3E);

    // R6 / R7 / R11: random writes, readback against model
    for (int it = 0; it < 10; it++) begin
      v = 8'($urandom);
      k = int'($urandom % 3000);
      do_write(v);
      lock_m = lock_m | v[6];
      wait_edges(k);
      check("R11 random readback", bus_rdata, rd_exp(v[7], lock_m, k));
    end

    // R7: lock cannot be cleared by software
    do_write(8'h40);
    lock_m = 1'b1;
    do_write(8'h00);
    check("R7 lock sticky", bus_rdata, 8'h7F);

    // R8 / R9: locked stop strobe fires next edge and clears state
    @(negedge clk); stop_exec = 1'b1;
    @(negedge clk); stop_exec = 1'b0;
    check("R8 locked stop pulse", {7'd0, wdt_rst_pulse}, 8'h01);
    @(negedge clk);
    check("R9 lock cleared by pulse", bus_rdata, 8'h3F);
    lock_m = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule